// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32.768 kHz timebase tick into a programmable periodic event and keeps the status flags that a clock-calendar's host reads to learn why it was interrupted. A binary divider chain counts timebase ticks while a three-bit chain control field holds the "run" pattern. A four-bit rate code picks one power-of-two tap of that chain, from 2 Hz up to 8192 Hz. The same tap, gated by a square-wave enable, drives a 50 % duty square-wave pin.

Two flags live in the status byte: a periodic flag, set at the end of every selected period, and an alarm flag, set by an external alarm-match pulse. Flags are set whatever their enables say. Only the active-low interrupt line is gated by the periodic and alarm enables, and the status byte's top bit mirrors that line. A read strobe on the status byte clears the flags and releases the interrupt one cycle later.

Two small state machines carry the control. The chain machine has states CH_HALT and CH_RUN, with transitions START (control field equals 010) and STOP (any other value). While halted, the counter is held at zero. The interrupt machine has states IRQ_QUIET and IRQ_DRIVEN, with transitions RAISE (an enabled flag will be set) and DROP (no enabled flag remains).

Top module: `periodic_irq_gen`

## Requirements
- R1: With the chain running and `tick_i` high, rate code c in 3..15 produces one periodic event every 2^(c-1) ticks, code 1 every 128 ticks and code 2 every 256 ticks. Cycles without a tick do not advance the chain. After the chain starts from zero, the first event comes on the 2^k-th counted tick.
- R2: Rate code 0 produces no periodic event and holds `sqw_o` low.
- R3: The chain runs only while `div_ctl_i` equals 3'b010, one cycle after that value is sampled (state CH_RUN). Any other value halts it (state CH_HALT) and clears the count, so no periodic event occurs while halted.
- R4: Status bit 6 (periodic flag) is set at the clock edge of each periodic event, whatever the value of `pie_i`.
- R5: Status bit 5 (alarm flag) is set at the edge that samples `alarm_hit_i` high, whatever the value of `aie_i`.
- R6: Status bit 7 is registered as (next periodic flag AND `pie_i`) OR (next alarm flag AND `aie_i`). `irq_n_o` is low exactly when bit 7 is 1.
- R7: A cycle with `stat_rd_i` high clears bits 7, 6 and 5 at the next edge. A flag whose set condition occurs in the same cycle as the read stays set.
- R8: `sqw_o` equals `sqwe_i` AND chain running AND bit (k-1) of the tick count, where 2^k is the selected period. This gives a square wave of period 2^k ticks that is low in the first half.
- R9: Status bits 4 to 0 always read 0.
- R10: After reset the status byte is 0x00, `irq_n_o` is 1, `sqw_o` is 0 and the chain is halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle 32.768 kHz timebase tick |
| rate_sel_i | input | 4 | Periodic rate code |
| div_ctl_i | input | 3 | Chain control field; 3'b010 runs the chain |
| pie_i | input | 1 | Periodic interrupt enable |
| aie_i | input | 1 | Alarm interrupt enable |
| sqwe_i | input | 1 | Square-wave output enable |
| alarm_hit_i | input | 1 | Alarm-match pulse |
| stat_rd_i | input | 1 | Status byte read strobe (clears flags) |
| stat_o | output | 8 | Status byte: bit 7 IRQ, bit 6 periodic, bit 5 alarm |
| irq_n_o | output | 1 | Active-low interrupt request |
| sqw_o | output | 1 | Square-wave output |

## Verification
The hardest situations to reach from the ports are the slowest rate and the collisions between a read and a flag set. At 2 Hz an event needs 16384 counted ticks. A read that lands in the exact cycle of a period end is rare under random stimulus. The bench holds `tick_i` high every cycle for directed period measurements at codes 1, 2, 3, 4 and 15. It also runs a stretch that reads the status byte every cycle, so that period ends and alarm pulses are sure to collide with reads. A constrained-random phase mixes short periods, tick gaps, chain halts and enable changes against a cycle-level reference model.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    typedef enum logic {
        CH_HALT = 1'b0,
        CH_RUN  = 1'b1
    } chain_st_e;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_DRIVEN = 1'b1
    } irq_st_e;

    localparam logic [2:0] RUN_PATTERN = 3'b010;
    localparam int IRQF_BIT = 7;
    localparam int PF_BIT   = 6;
    localparam int AF_BIT   = 5;
    localparam int LOW_CODE1_EXP = 7;
    localparam int LOW_CODE2_EXP = 8;

    // Period exponent k (period = 2^k ticks); 0 means no periodic event.
    function automatic int rate_exponent(input int code);
        if (code == 0)      return 0;
        else if (code == 1) return LOW_CODE1_EXP;
        else if (code == 2) return LOW_CODE2_EXP;
        else                return code - 1;
    endfunction

endpackage

// File: rtl/pirq_chain.sv
module pirq_chain
    import pirq_pkg::*;
#(
    parameter int CNT_W = 14,
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [DIV_W-1:0] div_ctl,
    output logic             run,
    output logic [CNT_W-1:0] cnt
);

    chain_st_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_HALT: if (div_ctl == RUN_PATTERN) state_d = CH_RUN;   // START
            CH_RUN:  if (div_ctl != RUN_PATTERN) state_d = CH_HALT;  // STOP
            default: state_d = CH_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_HALT;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        run = 1'b0;
        unique case (state_q)
            CH_HALT: run = 1'b0;
            CH_RUN:  run = 1'b1;
            default: run = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (!run)   cnt <= '0;
        else if (tick)   cnt <= cnt + 1'b1;
    end

    // R3: a halted chain never moves its count
    a_r3_halt_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && $past(!run)) |-> (cnt == '0));

endmodule

// File: rtl/pirq_tap.sv
module pirq_tap
    import pirq_pkg::*;
#(
    parameter int CNT_W = 14,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic [SEL_W-1:0] rate_sel,
    input  logic             sqwe,
    output logic             period_evt,
    output logic             sqw_lvl
);

    localparam int EXP_W = $clog2(CNT_W + 1);

    logic [CNT_W:0] wrap_at;   // wrap_at[k]: low k bits all ones
    logic [CNT_W:0] half_at;   // half_at[k]: second half of a 2^k period
    logic [EXP_W-1:0] exp_sel;

    assign wrap_at[0] = 1'b0;
    assign half_at[0] = 1'b0;

    for (genvar k = 1; k <= CNT_W; k++) begin : g_tap
        assign wrap_at[k] = &cnt[k-1:0];
        assign half_at[k] = cnt[k-1];
    end

    always_comb begin
        int e;
        e = rate_exponent(int'(rate_sel));
        if (e > CNT_W) e = CNT_W;
        exp_sel = EXP_W'(e);
    end

    assign period_evt = run && tick && wrap_at[exp_sel];
    assign sqw_lvl    = sqwe && run && half_at[exp_sel];

    // R1: events only come on counted ticks
    a_r1_event_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        period_evt |-> (tick && run));
    // R2: code zero never yields an event or a wave
    a_r2_code0_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == '0) |-> (!period_evt && !sqw_lvl));

endmodule

// File: rtl/pirq_flags.sv
module pirq_flags
    import pirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic period_evt,
    input  logic alarm_hit,
    input  logic stat_rd,
    input  logic pie,
    input  logic aie,
    output logic pf,
    output logic af,
    output logic irq_act
);

    logic pf_d, af_d, want_irq;
    irq_st_e state_q, state_d;

    // set wins over a read in the same cycle
    assign pf_d     = period_evt | (pf & ~stat_rd);
    assign af_d     = alarm_hit  | (af & ~stat_rd);
    assign want_irq = (pf_d & pie) | (af_d & aie);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pf <= 1'b0;
            af <= 1'b0;
        end else begin
            pf <= pf_d;
            af <= af_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (want_irq)  state_d = IRQ_DRIVEN;  // RAISE
            IRQ_DRIVEN: if (!want_irq) state_d = IRQ_QUIET;   // DROP
            default: state_d = IRQ_QUIET;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        irq_act = 1'b0;
        unique case (state_q)
            IRQ_QUIET:  irq_act = 1'b0;
            IRQ_DRIVEN: irq_act = 1'b1;
            default:    irq_act = 1'b0;
        endcase
    end

    // R4: a period end always leaves the periodic flag set
    a_r4_event_sets_pf: assert property (@(posedge clk) disable iff (!rst_n)
        period_evt |=> pf);
    // R5: an alarm pulse always leaves the alarm flag set
    a_r5_alarm_sets_af: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> af);
    // R6: the interrupt is driven only by an enabled flag
    a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_act |-> ((pf && $past(pie)) || (af && $past(aie))));
    // R7: a read with no new set condition clears everything
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !period_evt && !alarm_hit) |=> (!pf && !af && !irq_act));

endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen
    import pirq_pkg::*;
#(
    parameter int SEL_W = 4,
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [SEL_W-1:0] rate_sel_i,
    input  logic [DIV_W-1:0] div_ctl_i,
    input  logic             pie_i,
    input  logic             aie_i,
    input  logic             sqwe_i,
    input  logic             alarm_hit_i,
    input  logic             stat_rd_i,
    output logic [7:0]       stat_o,
    output logic             irq_n_o,
    output logic             sqw_o
);

    // the top code selects a period of 2^(2^SEL_W - 2) ticks
    localparam int CNT_W = (1 << SEL_W) - 2;

    logic             run;
    logic [CNT_W-1:0] cnt;
    logic             period_evt;
    logic             pf, af, irq_act;

    pirq_chain #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_i),
        .div_ctl (div_ctl_i),
        .run     (run),
        .cnt     (cnt)
    );

    pirq_tap #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_tap (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .tick       (tick_i),
        .cnt        (cnt),
        .rate_sel   (rate_sel_i),
        .sqwe       (sqwe_i),
        .period_evt (period_evt),
        .sqw_lvl    (sqw_o)
    );

    pirq_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_evt (period_evt),
        .alarm_hit  (alarm_hit_i),
        .stat_rd    (stat_rd_i),
        .pie        (pie_i),
        .aie        (aie_i),
        .pf         (pf),
        .af         (af),
        .irq_act    (irq_act)
    );

    always_comb begin
        stat_o           = 8'h00;   // R9: low bits stay zero
        stat_o[IRQF_BIT] = irq_act;
        stat_o[PF_BIT]   = pf;
        stat_o[AF_BIT]   = af;
    end

    assign irq_n_o = ~irq_act;

    // R10: quiet pins while in reset
    a_r10_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (stat_o == 8'h00 && irq_n_o && !sqw_o));

endmodule

// File: tb/periodic_irq_gen_test.sv
module periodic_irq_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [3:0] rate_sel_i = 4'h0;
    logic [2:0] div_ctl_i = 3'b000;
    logic       pie_i = 1'b0, aie_i = 1'b0, sqwe_i = 1'b0;
    logic       alarm_hit_i = 1'b0, stat_rd_i = 1'b0;
    logic [7:0] stat_o;
    logic       irq_n_o, sqw_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    periodic_irq_gen uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rate_sel_i(rate_sel_i),
        .div_ctl_i(div_ctl_i), .pie_i(pie_i), .aie_i(aie_i), .sqwe_i(sqwe_i),
        .alarm_hit_i(alarm_hit_i), .stat_rd_i(stat_rd_i),
        .stat_o(stat_o), .irq_n_o(irq_n_o), .sqw_o(sqw_o)
    );

    // ---------------- reference model from the requirements ----------------
    function automatic int period_exp(input logic [3:0] code);
        case (code)
            4'h0: return 0;
            4'h1: return 7;
            4'h2: return 8;
            default: return int'(code) - 1;
        endcase
    endfunction

    bit        m_run;
    bit [13:0] m_cnt;
    bit        m_pf, m_af, m_irq;

    always @(posedge clk) begin
        int  k;
        int  mask;
        bit  evt, npf, naf;
        if (!rst_n) begin
            m_run <= 0; m_cnt <= 0; m_pf <= 0; m_af <= 0; m_irq <= 0;
        end else begin
            k    = period_exp(rate_sel_i);
            mask = (1 << k) - 1;
            evt  = m_run && tick_i && (k != 0) && ((int'(m_cnt) & mask) == mask);
            npf  = evt | (m_pf & ~stat_rd_i);
            naf  = alarm_hit_i | (m_af & ~stat_rd_i);
            m_pf  <= npf;
            m_af  <= naf;
            m_irq <= (npf & pie_i) | (naf & aie_i);
            m_run <= (div_ctl_i == 3'b010);
            if (!m_run)      m_cnt <= 0;
            else if (tick_i) m_cnt <= m_cnt + 1;
        end
    end

    function automatic bit exp_sqw();
        int k;
        k = period_exp(rate_sel_i);
        return sqwe_i && m_run && (k != 0) && m_cnt[k-1];
    endfunction

    task automatic check(input string tag, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    // compare all outputs against the model; called at a negedge before driving
    task automatic compare_all();
        check("R4 periodic flag bit6", int'(stat_o[6]), int'(m_pf));
        check("R5 alarm flag bit5", int'(stat_o[5]), int'(m_af));
        check("R6 irq bit7", int'(stat_o[7]), int'(m_irq));
        check("R6 irq_n pin", int'(irq_n_o), int'(!m_irq));
        check("R9 low bits zero", int'(stat_o[4:0]), 0);
        check("R8 square wave", int'(sqw_o), int'(exp_sqw()));
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    // measure ticks to first periodic flag after restarting the chain
    task automatic measure(input logic [3:0] code);
        int k, n;
        k = period_exp(code);
        rate_sel_i = code; tick_i = 1; stat_rd_i = 1; alarm_hit_i = 0;
        div_ctl_i = 3'b000;
        step();
        stat_rd_i = 0;
        step();
        div_ctl_i = 3'b010;
        n = 0;
        do begin
            step();
            n++;
        end while (!stat_o[6] && n < 20000);
        check($sformatf("R1 first event code %0h", code), n, (1 << k) + 1);
    endtask

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        check("R10 reset stat", int'(stat_o), 0);
        check("R10 reset irq_n", int'(irq_n_o), 1);
        check("R10 reset sqw", int'(sqw_o), 0);
        rst_n = 1;
        step();

        // R1: directed periods with a tick every cycle
        pie_i = 1; sqwe_i = 1;
        measure(4'h3);
        measure(4'h4);
        measure(4'h1);
        measure(4'h2);
        measure(4'hF);

        // R2: code 0 never sets the periodic flag
        begin
            int seen = 0;
            rate_sel_i = 4'h0; stat_rd_i = 1; step(); stat_rd_i = 0;
            repeat (600) begin step(); if (stat_o[6] || sqw_o) seen++; end
            check("R2 code0 no event/wave", seen, 0);
        end

        // R3: chain held for non-run patterns
        begin
            int seen = 0;
            rate_sel_i = 4'h3;
            for (int p = 0; p < 8; p++) begin
                if (p == 2) continue;
                div_ctl_i = 3'(p);
                stat_rd_i = 1; step(); step(); stat_rd_i = 0;
                repeat (40) begin step(); if (stat_o[6]) seen++; end
            end
            check("R3 halted chain no event", seen, 0);
        end

        // R7: read every cycle, colliding with events and alarms; R4/R5 flags with enables off
        div_ctl_i = 3'b010; rate_sel_i = 4'h3; pie_i = 0; aie_i = 0; stat_rd_i = 1;
        for (int i = 0; i < 200; i++) begin
            alarm_hit_i = (i % 7 == 3);
            step();
        end
        stat_rd_i = 0; alarm_hit_i = 0;
        step();
        check("R7 no irq with enables off", int'(irq_n_o), 1);

        // constrained random mix
        for (int i = 0; i < 40000; i++) begin
            tick_i      = ($urandom_range(0, 3) != 0);
            alarm_hit_i = ($urandom_range(0, 15) == 0);
            stat_rd_i   = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 63) == 0) pie_i  = $urandom_range(0, 1);
            if ($urandom_range(0, 63) == 0) aie_i  = $urandom_range(0, 1);
            if ($urandom_range(0, 63) == 0) sqwe_i = $urandom_range(0, 1);
            if ($urandom_range(0, 255) == 0)
                rate_sel_i = ($urandom_range(0, 9) == 0) ? 4'h0 : 4'($urandom_range(3, 7));
            if ($urandom_range(0, 511) == 0)
                div_ctl_i = ($urandom_range(0, 1) != 0) ? 3'b010 : 3'($urandom_range(0, 7));
            step();
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule